// File: doc/BRIEF.md
# Arithmetic Error Trap Detector

This block sits beside the result path of a signed DSP datapath that has several 40-bit accumulators, each holding 32 data bits under 8 guard bits, plus a divider and a barrel shifter. For each completing operation it reads the result signals, not the operands, and decides whether a math-error trap must be raised. There are four causes: a divide with a zero divisor, an overflow of an accumulator result out of the 32-bit data field into the guard bits, a catastrophic overflow out of the 40-bit accumulator while every saturation mode is off, and a shift whose amount is larger than the legal maximum. The block does no arithmetic.

For every operation the datapath presents the operation kind, the selected accumulator, the 41-bit pre-saturation result (the stored 40 bits with the ideal sign bit above them), the divisor and the signed shift amount, together with a strobe. The trap request and the divide-abort signal come out in the same cycle as that strobe. Each cause also sets its own sticky status bit. Only a write-one-to-clear from software clears a status bit.

Top module: `mathtrap_detector`

## Requirements
- R1: With `op_valid` high, `op_kind` = 2 (divide) and `divisor` equal to zero, `trap_req` and `div_abort` are both high in that same cycle, and status bit 0 is set at the next clock edge. A non-zero divisor raises neither output.
- R2: With `op_valid` high, `op_kind` = 1 (accumulator arithmetic) and `ovf_en` high, a result whose bits 39:32 are not all equal to bit 31 raises `trap_req`. Status bit 1 is set when `acc_sel` = 0 (accumulator A) and bit 2 when `acc_sel` = 1 (accumulator B). With `ovf_en` low the check raises nothing.
- R3: With `op_valid` high, `op_kind` = 1, `cat_en` high and `sat_mask` = 0, a result whose bit 40 differs from bit 39 raises `trap_req`. It sets status bit 3 for accumulator A and bit 4 for accumulator B.
- R4: When any bit of `sat_mask` is set, the catastrophic-overflow check raises no trap and sets neither status bit 3 nor status bit 4, even with `cat_en` high.
- R5: The shift amount is a signed two's-complement value, and its magnitude is compared against a limit. The limit is 16 for `op_kind` = 3 (data shift) and 15 for `op_kind` = 4 (accumulator shift). A magnitude above the limit raises `trap_req` and sets status bit 5. A magnitude equal to the limit raises nothing.
- R6: `trap_req` is never high while `op_valid` is low. When the strobe is absent, operands that would otherwise trap raise nothing and change no status bit.
- R7: Status bits are sticky. Writing a one to a bit of `status_clr` clears that bit at the next edge. If a bit is cleared and set in the same cycle, the set wins. Bits that are not written keep their value.
- R8: Reset (`rst_n` low) clears all status bits. The status layout is: 0 divide-by-zero, 1 overflow A, 2 overflow B, 3 catastrophic A, 4 catastrophic B, 5 shift range.
- R9: Each check applies only to its own operation kind. Overflow results and shift amounts do not trap on a divide, a zero divisor does not trap on arithmetic, and `op_kind` = 0 never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | A datapath operation completes this cycle |
| op_kind | input | 3 | 0 none, 1 accumulator arithmetic, 2 divide, 3 data shift, 4 accumulator shift |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| acc_result | input | 41 | Pre-saturation result: bit 40 is the ideal sign, bits 39:0 are the stored value |
| divisor | input | 16 | Divisor of the divide operation |
| shift_amt | input | 6 | Signed shift amount |
| ovf_en | input | 1 | Enables the guard-bit overflow trap |
| cat_en | input | 1 | Enables the catastrophic-overflow trap |
| sat_mask | input | 3 | Saturation mode bits; any set bit blocks the catastrophic trap |
| status_clr | input | 6 | Write-one-to-clear for the status bits |
| trap_req | output | 1 | Math-error trap request, aligned with op_valid |
| div_abort | output | 1 | Abort of the current divide |
| trap_status | output | 6 | Sticky per-cause status |

## Verification
The bench probes both shift limits on each side and with both signs: +16 and −16 are legal for a data shift while 17 and −17 are not, and 15 is legal for an accumulator shift while 16 is not. A design with an off-by-one limit, or one that takes the raw bits of a negative amount as its magnitude, would trap at the wrong point. The bench also sends a catastrophic overflow with a saturation mode on, to catch a design that ignores `sat_mask`, and it sends a clear and a set to the same status bit in one cycle, where a design with the priority reversed would lose the event. Overflow results on the wrong operation kind, and a zero divisor without the strobe, expose decoders that trap too widely or do not gate on `op_valid`.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_ARITH     = 3'd1,
      OP_DIV       = 3'd2,
      OP_SHIFT_DAT = 3'd3,
      OP_SHIFT_ACC = 3'd4
   } op_kind_e;

   localparam int unsigned CAUSE_DIV0 = 0;

endpackage

// File: rtl/mtrap_acc_guard.sv
// Inspects the top of one accumulator result: ideal sign, guard field, data MSB.
module mtrap_acc_guard #(
   parameter int unsigned GUARD_W = 8
) (
   input  logic [GUARD_W+1:0] top_bits,   // [GUARD_W+1]=ideal sign, [GUARD_W:1]=guard, [0]=data MSB
   output logic               guard_ovf,
   output logic               cat_ovf
);

   localparam int unsigned TOP_W = GUARD_W + 2;

   logic              data_msb;
   logic [GUARD_W-1:0] guard;
   logic              ideal_sign;
   logic              stored_sign;

   assign data_msb    = top_bits[0];
   assign guard       = top_bits[GUARD_W:1];
   assign ideal_sign  = top_bits[TOP_W-1];
   assign stored_sign = top_bits[GUARD_W];

   // Result leaves the data field when the guard field is not a sign extension of it.
   assign guard_ovf = (guard != {GUARD_W{data_msb}});
   // Result leaves the whole accumulator when the stored sign is not the ideal sign.
   assign cat_ovf   = (ideal_sign != stored_sign);

endmodule

// File: rtl/mtrap_shift_range.sv
module mtrap_shift_range #(
   parameter int unsigned SHIFT_W  = 6,
   parameter int unsigned DATA_MAX = 16,
   parameter int unsigned ACC_MAX  = 15
) (
   input  logic [SHIFT_W-1:0] amt,      // signed two's complement
   input  logic               is_acc,
   output logic               too_far
);

   localparam logic [SHIFT_W-1:0] DATA_LIM = SHIFT_W'(DATA_MAX);
   localparam logic [SHIFT_W-1:0] ACC_LIM  = SHIFT_W'(ACC_MAX);
   localparam logic [SHIFT_W-1:0] ONE      = {{(SHIFT_W-1){1'b0}}, 1'b1};

   logic [SHIFT_W-1:0] mag;

   // Magnitude of the most negative code fits unsigned in SHIFT_W bits.
   assign mag = amt[SHIFT_W-1] ? (~amt + ONE) : amt;

   generate
      if (DATA_MAX == ACC_MAX) begin : g_one_limit
         logic unused_sel;
         assign unused_sel = is_acc;
         assign too_far    = (mag > DATA_LIM);
      end else begin : g_two_limits
         logic over_data;
         logic over_acc;
         assign over_data = (mag > DATA_LIM);
         assign over_acc  = (mag > ACC_LIM);
         assign too_far   = is_acc ? over_acc : over_data;
      end
   endgenerate

endmodule

// File: rtl/mtrap_sticky.sv
module mtrap_sticky #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);

   logic [N-1:0] flags_q;

   // A new event outranks a clear of the same bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr) | set;
   end

   assign flags = flags_q;

endmodule

// File: rtl/mathtrap_detector.sv
module mathtrap_detector
   import mtrap_pkg::*;
#(
   parameter int unsigned NUM_ACC    = 2,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned GUARD_W    = 8,
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned SHIFT_W    = 6,
   parameter int unsigned DATA_SHMAX = 16,
   parameter int unsigned ACC_SHMAX  = 15,
   parameter int unsigned SAT_W      = 3,
   localparam int unsigned SEL_W     = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
   localparam int unsigned RES_W     = DATA_W + GUARD_W + 1,
   localparam int unsigned NCAUSE    = 2 * NUM_ACC + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_kind,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic [RES_W-1:0]  acc_result,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [SHIFT_W-1:0] shift_amt,
   input  logic              ovf_en,
   input  logic              cat_en,
   input  logic [SAT_W-1:0]  sat_mask,
   input  logic [NCAUSE-1:0] status_clr,
   output logic              trap_req,
   output logic              div_abort,
   output logic [NCAUSE-1:0] trap_status
);

   localparam int unsigned OVF_BASE = CAUSE_DIV0 + 1;
   localparam int unsigned CAT_BASE = OVF_BASE + NUM_ACC;
   localparam int unsigned SHF_BIT  = CAT_BASE + NUM_ACC;
   localparam int unsigned TOP_LSB  = DATA_W - 1;

   // Elaboration-time parameter checks
   generate
      if (NUM_ACC < 1)                         begin : g_bad_nacc  $error("NUM_ACC must be at least 1"); end
      if (GUARD_W < 1)                         begin : g_bad_guard $error("GUARD_W must be at least 1"); end
      if (DIV_W < 1)                           begin : g_bad_div   $error("DIV_W must be at least 1"); end
      if (SAT_W < 1)                           begin : g_bad_sat   $error("SAT_W must be at least 1"); end
      if (DATA_SHMAX >= (1 << (SHIFT_W - 1)))  begin : g_bad_dsh   $error("DATA_SHMAX must be representable below the shift range"); end
      if (ACC_SHMAX  >= (1 << (SHIFT_W - 1)))  begin : g_bad_ash   $error("ACC_SHMAX must be representable below the shift range"); end
   endgenerate

   // Operation decode
   logic is_arith, is_div, is_shift, is_acc_shift;
   assign is_arith     = op_valid && (op_kind == OP_ARITH);
   assign is_div       = op_valid && (op_kind == OP_DIV);
   assign is_acc_shift = (op_kind == OP_SHIFT_ACC);
   assign is_shift     = op_valid && ((op_kind == OP_SHIFT_DAT) || is_acc_shift);

   logic sat_all_off;
   assign sat_all_off = (sat_mask == '0);

   logic [NCAUSE-1:0] cause;

   // Divide by zero
   logic div_zero;
   assign div_zero          = is_div && (divisor == '0);
   assign cause[CAUSE_DIV0] = div_zero;
   assign div_abort         = div_zero;

   // Per-accumulator overflow checks; every instance sees the result, only the selected one reports
   logic guard_ovf, cat_ovf;

   mtrap_acc_guard #(.GUARD_W(GUARD_W)) u_guard (
      .top_bits  (acc_result[RES_W-1:TOP_LSB]),
      .guard_ovf (guard_ovf),
      .cat_ovf   (cat_ovf)
   );

   generate
      for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
         logic hit;
         if (NUM_ACC > 1) begin : g_multi
            assign hit = is_arith && (acc_sel == SEL_W'(g));
         end else begin : g_single
            logic unused_sel;
            assign unused_sel = |acc_sel;
            assign hit        = is_arith;
         end
         assign cause[OVF_BASE + g] = hit && ovf_en && guard_ovf;
         assign cause[CAT_BASE + g] = hit && cat_en && sat_all_off && cat_ovf;
      end
   endgenerate

   // Shift range
   logic shift_far;

   mtrap_shift_range #(
      .SHIFT_W  (SHIFT_W),
      .DATA_MAX (DATA_SHMAX),
      .ACC_MAX  (ACC_SHMAX)
   ) u_shift (
      .amt     (shift_amt),
      .is_acc  (is_acc_shift),
      .too_far (shift_far)
   );

   assign cause[SHF_BIT] = is_shift && shift_far;

   // Trap pulse aligned with the strobe
   assign trap_req = |cause;

   mtrap_sticky #(.N(NCAUSE)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (cause),
      .clr   (status_clr),
      .flags (trap_status)
   );

endmodule

// File: rtl/mtrap_checker.sv
module mtrap_checker
   import mtrap_pkg::*;
#(
   parameter int unsigned NUM_ACC = 2,
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned SAT_W   = 3,
   parameter int unsigned NCAUSE  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_kind,
   input logic [DIV_W-1:0]  divisor,
   input logic [SAT_W-1:0]  sat_mask,
   input logic [NCAUSE-1:0] status_clr,
   input logic              trap_req,
   input logic              div_abort,
   input logic [NCAUSE-1:0] trap_status
);

   localparam logic [NCAUSE-1:0] CAT_MASK =
      NCAUSE'(((1 << NUM_ACC) - 1) << (NUM_ACC + 1));

   // R6
   p_trap_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> op_valid);

   // R1
   p_div_zero_aborts_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == OP_DIV && divisor == '0) |-> (div_abort && trap_req));

   p_abort_only_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
      div_abort |-> (op_valid && op_kind == OP_DIV && divisor == '0));

   // R7
   p_trap_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (trap_status != '0));

   p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((trap_status & $past(trap_status & ~status_clr)) == $past(trap_status & ~status_clr)));

   // R4
   p_sat_blocks_cat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && sat_mask != '0 && (trap_status & CAT_MASK) == '0) |=> ((trap_status & CAT_MASK) == '0));

endmodule

bind mathtrap_detector mtrap_checker #(
   .NUM_ACC (NUM_ACC),
   .DIV_W   (DIV_W),
   .SAT_W   (SAT_W),
   .NCAUSE  (NCAUSE)
) u_mtrap_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .op_kind     (op_kind),
   .divisor     (divisor),
   .sat_mask    (sat_mask),
   .status_clr  (status_clr),
   .trap_req    (trap_req),
   .div_abort   (div_abort),
   .trap_status (trap_status)
);

// File: tb/tb_mathtrap_detector.sv
module tb_mathtrap_detector;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_kind = 3'd0;
   logic [0:0]  acc_sel = 1'b0;
   logic [40:0] acc_result = '0;
   logic [15:0] divisor = 16'd1;
   logic [5:0]  shift_amt = '0;
   logic        ovf_en = 1'b0;
   logic        cat_en = 1'b0;
   logic [2:0]  sat_mask = '0;
   logic [5:0]  status_clr = '0;
   logic        trap_req;
   logic        div_abort;
   logic [5:0]  trap_status;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic got_trap, got_abort;

   localparam logic [2:0] K_NONE = 3'd0, K_ARITH = 3'd1, K_DIV = 3'd2,
                          K_SHD = 3'd3, K_SHA = 3'd4;
   localparam logic [40:0] RES_OK    = 41'h1_FF_8000_0000;  // negative, fits 32 bits
   localparam logic [40:0] RES_OVF31 = 41'h0_00_8000_0000;  // guard 0 under data MSB 1
   localparam logic [40:0] RES_CAT   = 41'h0_80_0000_0000;  // bit40=0, bit39=1

   always #10 clk = ~clk;   // 50 MHz

   mathtrap_detector dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .acc_sel(acc_sel), .acc_result(acc_result), .divisor(divisor),
      .shift_amt(shift_amt), .ovf_en(ovf_en), .cat_en(cat_en),
      .sat_mask(sat_mask), .status_clr(status_clr), .trap_req(trap_req),
      .div_abort(div_abort), .trap_status(trap_status)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [40:0] act, input logic [40:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One operation: capture same-cycle outputs, then status after the edge.
   task automatic run_op(input logic vld, input logic [2:0] kind, input logic sel,
                         input logic [40:0] res, input logic [15:0] dv,
                         input logic [5:0] sh, input logic [5:0] clr);
      @(posedge clk); #2;
      op_valid = vld; op_kind = kind; acc_sel = sel; acc_result = res;
      divisor = dv; shift_amt = sh; status_clr = clr;
      @(negedge clk);
      got_trap  = trap_req;
      got_abort = div_abort;
      @(posedge clk); #2;
      op_valid = 1'b0; status_clr = '0; op_kind = K_NONE;
      @(negedge clk);
   endtask

   task automatic clear_all();
      run_op(1'b0, K_NONE, 1'b0, RES_OK, 16'd1, 6'd0, 6'h3F);
   endtask

   task automatic t_reset();   // R8
      @(negedge clk);
      check(trap_status == 6'h00, "R8", "status after reset", trap_status, 6'h00);
      check(trap_req == 1'b0, "R8", "trap idle after reset", trap_req, 1'b0);
   endtask

   task automatic t_divide();  // R1
      run_op(1'b1, K_DIV, 1'b0, RES_OK, 16'd7, 6'd0, 6'h00);
      check(!got_trap && !got_abort, "R1", "nonzero divisor trap/abort", {got_trap, got_abort}, 2'b00);
      run_op(1'b1, K_DIV, 1'b0, RES_OK, 16'd0, 6'd0, 6'h00);
      check(got_trap && got_abort, "R1", "zero divisor trap/abort", {got_trap, got_abort}, 2'b11);
      check(trap_status == 6'h01, "R1", "div status bit 0", trap_status, 6'h01);
      clear_all();
   endtask

   task automatic t_overflow(); // R2
      ovf_en = 1'b0;
      run_op(1'b1, K_ARITH, 1'b0, RES_OVF31, 16'd1, 6'd0, 6'h00);
      check(!got_trap, "R2", "overflow disabled trap", got_trap, 1'b0);
      check(trap_status == 6'h00, "R2", "overflow disabled status", trap_status, 6'h00);
      ovf_en = 1'b1;
      run_op(1'b1, K_ARITH, 1'b0, RES_OK, 16'd1, 6'd0, 6'h00);
      check(!got_trap, "R2", "in-range negative result trap", got_trap, 1'b0);
      run_op(1'b1, K_ARITH, 1'b0, RES_OVF31, 16'd1, 6'd0, 6'h00);
      check(got_trap, "R2", "overflow A trap", got_trap, 1'b1);
      check(trap_status == 6'h02, "R2", "overflow A status", trap_status, 6'h02);
      run_op(1'b1, K_ARITH, 1'b1, 41'h1_FE_FFFF_FFFF, 16'd1, 6'd0, 6'h00);
      check(got_trap, "R2", "overflow B trap", got_trap, 1'b1);
      check(trap_status == 6'h06, "R2", "overflow B status", trap_status, 6'h06);
      ovf_en = 1'b0;
      clear_all();
   endtask

   task automatic t_catastrophic(); // R3
      cat_en = 1'b1; sat_mask = 3'b000;
      run_op(1'b1, K_ARITH, 1'b0, RES_CAT, 16'd1, 6'd0, 6'h00);
      check(got_trap, "R3", "catastrophic A trap", got_trap, 1'b1);
      check(trap_status == 6'h08, "R3", "catastrophic A status", trap_status, 6'h08);
      run_op(1'b1, K_ARITH, 1'b1, 41'h1_7F_FFFF_FFFF, 16'd1, 6'd0, 6'h00);
      check(trap_status == 6'h18, "R3", "catastrophic B status", trap_status, 6'h18);
      cat_en = 1'b0;
      clear_all();
   endtask

   task automatic t_saturation(); // R4
      cat_en = 1'b1; sat_mask = 3'b010;
      run_op(1'b1, K_ARITH, 1'b0, RES_CAT, 16'd1, 6'd0, 6'h00);
      check(!got_trap, "R4", "saturation on trap", got_trap, 1'b0);
      check(trap_status == 6'h00, "R4", "saturation on status", trap_status, 6'h00);
      cat_en = 1'b0; sat_mask = 3'b000;
   endtask

   task automatic t_shift(); // R5
      run_op(1'b1, K_SHD, 1'b0, RES_OK, 16'd1, 6'd16, 6'h00);
      check(!got_trap, "R5", "data shift +16", got_trap, 1'b0);
      run_op(1'b1, K_SHD, 1'b0, RES_OK, 16'd1, 6'h30, 6'h00);   // -16
      check(!got_trap, "R5", "data shift -16", got_trap, 1'b0);
      run_op(1'b1, K_SHA, 1'b0, RES_OK, 16'd1, 6'd15, 6'h00);
      check(!got_trap, "R5", "acc shift +15", got_trap, 1'b0);
      check(trap_status == 6'h00, "R5", "legal shifts status", trap_status, 6'h00);
      run_op(1'b1, K_SHD, 1'b0, RES_OK, 16'd1, 6'd17, 6'h00);
      check(got_trap, "R5", "data shift +17", got_trap, 1'b1);
      check(trap_status == 6'h20, "R5", "shift status bit 5", trap_status, 6'h20);
      run_op(1'b1, K_SHD, 1'b0, RES_OK, 16'd1, 6'h2F, 6'h00);   // -17
      check(got_trap, "R5", "data shift -17", got_trap, 1'b1);
      run_op(1'b1, K_SHA, 1'b0, RES_OK, 16'd1, 6'd16, 6'h00);
      check(got_trap, "R5", "acc shift +16", got_trap, 1'b1);
      clear_all();
   endtask

   task automatic t_no_strobe(); // R6
      run_op(1'b0, K_DIV, 1'b0, RES_OK, 16'd0, 6'd0, 6'h00);
      check(!got_trap && !got_abort, "R6", "no strobe trap/abort", {got_trap, got_abort}, 2'b00);
      check(trap_status == 6'h00, "R6", "no strobe status", trap_status, 6'h00);
   endtask

   task automatic t_sticky(); // R7
      run_op(1'b1, K_DIV, 1'b0, RES_OK, 16'd0, 6'd0, 6'h00);
      run_op(1'b1, K_SHD, 1'b0, RES_OK, 16'd1, 6'd20, 6'h00);
      run_op(1'b0, K_NONE, 1'b0, RES_OK, 16'd1, 6'd0, 6'h00);
      check(trap_status == 6'h21, "R7", "bits held", trap_status, 6'h21);
      run_op(1'b0, K_NONE, 1'b0, RES_OK, 16'd1, 6'd0, 6'h01);
      check(trap_status == 6'h20, "R7", "write-one clear of bit 0", trap_status, 6'h20);
      run_op(1'b1, K_SHD, 1'b0, RES_OK, 16'd1, 6'd20, 6'h20);
      check(trap_status == 6'h20, "R7", "set wins over clear", trap_status, 6'h20);
      clear_all();
   endtask

   task automatic t_kind_gating(); // R9
      ovf_en = 1'b1; cat_en = 1'b1;
      run_op(1'b1, K_DIV, 1'b0, RES_CAT, 16'd3, 6'd30, 6'h00);
      check(!got_trap, "R9", "overflow on divide", got_trap, 1'b0);
      run_op(1'b1, K_ARITH, 1'b0, RES_OK, 16'd0, 6'd30, 6'h00);
      check(!got_trap, "R9", "zero divisor and big shift on arithmetic", got_trap, 1'b0);
      run_op(1'b1, K_NONE, 1'b0, RES_CAT, 16'd0, 6'd30, 6'h00);
      check(!got_trap, "R9", "kind none", got_trap, 1'b0);
      check(trap_status == 6'h00, "R9", "status after wrong kinds", trap_status, 6'h00);
      ovf_en = 1'b0; cat_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_divide();
      t_overflow();
      t_catastrophic();
      t_saturation();
      t_shift();
      t_no_strobe();
      t_sticky();
      t_kind_gating();
      finish_run();
   end

endmodule